// File: doc/BRIEF.md
# BCD Calendar Time Register Bank

This block holds the time of day and the calendar date as a set of BCD byte registers. An external one-cycle enable, pulsed once per second, advances the time. Carries ripple from seconds up through minutes, hours, day of month, weekday, month and year. The day-of-month limit follows the current month. February gets a 29th day when the two-digit year is a multiple of four.

Software reads and writes the registers through a byte-wide port with a register index. The read data is combinational from the index. A write lands on the next clock edge. A control byte selects a 12-hour or 24-hour hours layout, can freeze counting, and can request a software reset. A sticky flag in the seconds byte records any oscillator-fail event reported on an input pin. Only software can clear it.

Top module: `bcd_clock_bank`

## Requirements
- R1: After reset the registers read: control 0x00, seconds 0x80 (flag set, count 00), minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00.
- R2: Each `tick_i` pulse while running adds one to seconds (BCD, index 0x03, bits 6:0). 59 goes to 00 and carries into minutes.
- R3: Minutes (index 0x04, bits 6:0, BCD) go 59 to 00 on a carry and pass the carry on to hours.
- R4: With control bit 3 at 0 (24-hour), hours (index 0x05, bits 5:0, BCD) go 23 to 00. That step carries into both date and weekday.
- R5: With control bit 3 at 1 (12-hour), hours bits 4:0 hold 01..12 in BCD and bit 5 is PM. The order is 11 AM, 12 PM, 01 PM, and 11 PM, 12 AM, 01 AM. Only the step from 11 PM to 12 AM carries into the date.
- R6: Date (index 0x06, bits 5:0, BCD) goes back to 01 after its last day and carries into month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on 29 when the BCD year is divisible by 4, and on 28 otherwise.
- R7: Month (index 0x08, bits 4:0, BCD 01..12) goes 12 to 01 and carries into year. Year (index 0x09, 8-bit BCD) counts 00..99 and wraps 99 to 00.
- R8: Weekday (index 0x07, bits 2:0) counts 0..6 and wraps to 0.
- R9: While control bit 5 is 1, ticks leave every time register unchanged. Clearing the bit resumes counting from the held value.
- R10: Seconds bit 7 is set by any cycle with `osc_fail_i` high and stays set. A seconds write with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it as it was. A fail event in the same cycle as a clearing write leaves it set.
- R11: A register write takes effect on the next clock edge. When a tick arrives in the same cycle, the written register takes the written value. A register being written passes no carry onward.
- R12: Writing control (index 0x00) with bit 4 at 1 returns every register to its R1 value on the next edge. Bit 4 always reads 0.
- R13: Indices other than 0x00 and 0x03..0x09 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 Hz time advance enable |
| osc_fail_i | input | 1 | Oscillator-fail event, sets the sticky flag |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register index for both reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |

## Verification
The range properties on seconds, date, month and weekday rely on software writing only legal BCD values within each field's range. The bench writes only such values. The hold checks assume that a cycle with neither a tick nor a write changes no time field. The sticky-flag checks treat a software reset as the only other way the flag can move. The bench drives reads only in cycles with no tick, write or fail event, so every sampled value is settled.

// File: rtl/bcd_clk_pkg.sv
package bcd_clk_pkg;

   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_SEC  = 3;
   localparam int unsigned IDX_MIN  = 4;
   localparam int unsigned IDX_HOUR = 5;
   localparam int unsigned IDX_DATE = 6;
   localparam int unsigned IDX_WDAY = 7;
   localparam int unsigned IDX_MON  = 8;
   localparam int unsigned IDX_YEAR = 9;

   localparam int unsigned CTL_MODE12 = 3;
   localparam int unsigned CTL_SWRST  = 4;
   localparam int unsigned CTL_HALT   = 5;

   typedef enum logic {HR_FMT_24 = 1'b0, HR_FMT_12 = 1'b1} hr_fmt_e;

   // BCD increment of a six-bit two-digit field
   function automatic logic [5:0] bcd_step6(input logic [5:0] v);
      if (v[3:0] == 4'd9) return {v[5:4] + 2'd1, 4'h0};
      else                return {v[5:4], v[3:0] + 4'd1};
   endfunction

   // a BCD year is a multiple of four: even tens with 0/4/8, odd tens with 2/6
   function automatic logic leap_bcd(input logic tens_odd, input logic [3:0] ones);
      if (tens_odd) return (ones == 4'd2) || (ones == 4'd6);
      else          return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
   endfunction

   function automatic logic [5:0] last_day(input logic [4:0] mon, input logic leap);
      case (mon)
         5'h02:                      return leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcd_wrap_cnt.sv
module bcd_wrap_cnt #(
   parameter int unsigned   W   = 8,
   parameter logic [W-1:0]  LO  = '0,
   parameter logic [W-1:0]  HI  = '0,
   parameter logic [W-1:0]  RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         step_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_r;
   logic [W-1:0] inc_v;

   if (W < 3 || W > 8) begin : g_bad_w
      $error("bcd_wrap_cnt: W must be 3..8");
   end

   if (W > 4) begin : g_bcd
      localparam int unsigned HW = W - 4;
      assign inc_v = (q_r[3:0] == 4'd9) ? {q_r[W-1:4] + HW'(1), 4'h0}
                                        : {q_r[W-1:4], q_r[3:0] + 4'd1};
   end else begin : g_bin
      assign inc_v = q_r + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_r <= RST;
      else if (clr_i)   q_r <= RST;
      else if (ld_i)    q_r <= ld_val_i;
      else if (step_i)  q_r <= (q_r == HI) ? LO : inc_v;
   end

   assign q_o = q_r;
endmodule

// File: rtl/bcd_hour_cnt.sv
module bcd_hour_cnt
   import bcd_clk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       ld_i,
   input  logic [5:0] ld_val_i,
   input  logic       step_i,
   input  hr_fmt_e    fmt_i,
   output logic [5:0] q_o,
   output logic       wrap_o
);
   logic [5:0] q_r;
   logic [5:0] nxt;
   logic       at_end;

   always_comb begin
      nxt    = bcd_step6(q_r);
      at_end = 1'b0;
      if (fmt_i == HR_FMT_12) begin
         if (q_r[4:0] == 5'h11) begin
            nxt    = {~q_r[5], 5'h12};
            at_end = q_r[5];
         end else if (q_r[4:0] == 5'h12) begin
            nxt = {q_r[5], 5'h01};
         end else begin
            nxt = bcd_step6({1'b0, q_r[4:0]}) | {q_r[5], 5'b0};
         end
      end else if (q_r == 6'h23) begin
         nxt    = 6'h00;
         at_end = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_r <= 6'h00;
      else if (clr_i)   q_r <= 6'h00;
      else if (ld_i)    q_r <= ld_val_i;
      else if (step_i)  q_r <= nxt;
   end

   assign q_o    = q_r;
   assign wrap_o = step_i & ~ld_i & ~clr_i & at_end;
endmodule

// File: rtl/bcd_date_cnt.sv
module bcd_date_cnt
   import bcd_clk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       ld_i,
   input  logic [5:0] ld_val_i,
   input  logic       step_i,
   input  logic [4:0] mon_i,
   input  logic       leap_i,
   output logic [5:0] q_o,
   output logic       wrap_o
);
   logic [5:0] q_r;
   logic       at_end;

   assign at_end = (q_r >= last_day(mon_i, leap_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_r <= 6'h01;
      else if (clr_i)   q_r <= 6'h01;
      else if (ld_i)    q_r <= ld_val_i;
      else if (step_i)  q_r <= at_end ? 6'h01 : bcd_step6(q_r);
   end

   assign q_o    = q_r;
   assign wrap_o = step_i & ~ld_i & ~clr_i & at_end;
endmodule

// File: rtl/bcd_clock_bank.sv
module bcd_clock_bank
   import bcd_clk_pkg::*;
#(
   parameter int unsigned ADDR_W            = 5,
   parameter bit          OSC_FLAG_AT_RESET = 1'b1,
   parameter bit          HR12_SUPPORT      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              osc_fail_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o
);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(IDX_CTRL);
   localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(IDX_SEC);
   localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(IDX_MIN);
   localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(IDX_HOUR);
   localparam logic [ADDR_W-1:0] A_DATE = ADDR_W'(IDX_DATE);
   localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(IDX_WDAY);
   localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(IDX_MON);
   localparam logic [ADDR_W-1:0] A_YEAR = ADDR_W'(IDX_YEAR);

   if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
      $error("bcd_clock_bank: ADDR_W must be 4..8");
   end

   logic       stop_q, mode12_q, osc_q;
   logic [6:0] sec_q, min_q;
   logic [5:0] hr_q, date_q;
   logic [2:0] wday_q;
   logic [4:0] mon_q;
   logic [7:0] yr_q;

   logic wr_ctrl, wr_sec, wr_min, wr_hour, wr_date, wr_wday, wr_mon, wr_year;
   logic soft_rst, run;
   logic c_sec, c_min, c_hr, c_date, c_mon;
   hr_fmt_e fmt;

   assign wr_ctrl  = we_i && (addr_i == A_CTRL);
   assign wr_sec   = we_i && (addr_i == A_SEC);
   assign wr_min   = we_i && (addr_i == A_MIN);
   assign wr_hour  = we_i && (addr_i == A_HOUR);
   assign wr_date  = we_i && (addr_i == A_DATE);
   assign wr_wday  = we_i && (addr_i == A_WDAY);
   assign wr_mon   = we_i && (addr_i == A_MON);
   assign wr_year  = we_i && (addr_i == A_YEAR);
   assign soft_rst = wr_ctrl && wdata_i[CTL_SWRST];
   assign run      = tick_i && !stop_q;

   // control byte and sticky oscillator flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q   <= 1'b0;
         mode12_q <= 1'b0;
      end else if (soft_rst) begin
         stop_q   <= 1'b0;
         mode12_q <= 1'b0;
      end else if (wr_ctrl) begin
         stop_q   <= wdata_i[CTL_HALT];
         mode12_q <= wdata_i[CTL_MODE12] & HR12_SUPPORT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          osc_q <= OSC_FLAG_AT_RESET;
      else if (osc_fail_i) osc_q <= 1'b1;
      else if (soft_rst)   osc_q <= OSC_FLAG_AT_RESET;
      else if (wr_sec)     osc_q <= osc_q & wdata_i[7];
   end

   assign fmt = mode12_q ? HR_FMT_12 : HR_FMT_24;

   // carry chain: a register under write passes nothing on
   assign c_sec = run   && !wr_sec && (sec_q == 7'h59);
   assign c_min = c_sec && !wr_min && (min_q == 7'h59);
   assign c_mon = c_date && !wr_mon && (mon_q == 5'h12);

   bcd_wrap_cnt #(.W(7), .LO(7'h00), .HI(7'h59), .RST(7'h00)) u_sec (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .ld_i(wr_sec),
      .ld_val_i(wdata_i[6:0]), .step_i(run), .q_o(sec_q));

   bcd_wrap_cnt #(.W(7), .LO(7'h00), .HI(7'h59), .RST(7'h00)) u_min (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .ld_i(wr_min),
      .ld_val_i(wdata_i[6:0]), .step_i(c_sec), .q_o(min_q));

   bcd_hour_cnt u_hour (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .ld_i(wr_hour),
      .ld_val_i(wdata_i[5:0]), .step_i(c_min), .fmt_i(fmt),
      .q_o(hr_q), .wrap_o(c_hr));

   bcd_date_cnt u_date (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .ld_i(wr_date),
      .ld_val_i(wdata_i[5:0]), .step_i(c_hr), .mon_i(mon_q),
      .leap_i(leap_bcd(yr_q[4], yr_q[3:0])), .q_o(date_q), .wrap_o(c_date));

   bcd_wrap_cnt #(.W(3), .LO(3'd0), .HI(3'd6), .RST(3'd0)) u_wday (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .ld_i(wr_wday),
      .ld_val_i(wdata_i[2:0]), .step_i(c_hr), .q_o(wday_q));

   bcd_wrap_cnt #(.W(5), .LO(5'h01), .HI(5'h12), .RST(5'h01)) u_mon (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .ld_i(wr_mon),
      .ld_val_i(wdata_i[4:0]), .step_i(c_date), .q_o(mon_q));

   bcd_wrap_cnt #(.W(8), .LO(8'h00), .HI(8'h99), .RST(8'h00)) u_year (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst), .ld_i(wr_year),
      .ld_val_i(wdata_i), .step_i(c_mon), .q_o(yr_q));

   always_comb begin
      case (addr_i)
         A_CTRL:  rdata_o = {2'b00, stop_q, 1'b0, mode12_q, 3'b000};
         A_SEC:   rdata_o = {osc_q, sec_q};
         A_MIN:   rdata_o = {1'b0, min_q};
         A_HOUR:  rdata_o = {2'b00, hr_q};
         A_DATE:  rdata_o = {2'b00, date_q};
         A_WDAY:  rdata_o = {5'b00000, wday_q};
         A_MON:   rdata_o = {3'b000, mon_q};
         A_YEAR:  rdata_o = yr_q;
         default: rdata_o = 8'h00;
      endcase
   end
endmodule

// File: rtl/bcd_clock_bank_chk.sv
module bcd_clock_bank_chk
   import bcd_clk_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              osc_fail_i,
   input logic              we_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [7:0]        wdata_i,
   input logic              stop_q,
   input logic              osc_q,
   input logic [6:0]        sec_q,
   input logic [6:0]        min_q,
   input logic [5:0]        hr_q,
   input logic [5:0]        date_q,
   input logic [2:0]        wday_q,
   input logic [4:0]        mon_q,
   input logic [7:0]        yr_q
);
   logic w_sec, w_min, w_swrst;
   assign w_sec   = we_i && (addr_i == ADDR_W'(IDX_SEC));
   assign w_min   = we_i && (addr_i == ADDR_W'(IDX_MIN));
   assign w_swrst = we_i && (addr_i == ADDR_W'(IDX_CTRL)) && wdata_i[CTL_SWRST];

   p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q <= 7'h59);

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !we_i) |=> $stable(sec_q) && $stable(min_q) && $stable(hr_q)
         && $stable(date_q) && $stable(wday_q) && $stable(mon_q) && $stable(yr_q));

   p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !we_i) |=> $stable(sec_q) && $stable(min_q) && $stable(hr_q)
         && $stable(date_q) && $stable(wday_q) && $stable(mon_q) && $stable(yr_q));

   p_date_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (date_q != 6'h00) && (date_q <= 6'h31));

   p_month_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_q >= 5'h01) && (mon_q <= 5'h12));

   p_wday_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wday_q <= 3'd6);

   p_osc_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      osc_fail_i |=> osc_q);

   p_osc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_q && !w_sec && !w_swrst) |=> osc_q);

   p_osc_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (w_sec && !wdata_i[7] && !osc_fail_i) |=> !osc_q);

   p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      w_min |=> (min_q == $past(wdata_i[6:0])));

   p_swrst_r12: assert property (@(posedge clk) disable iff (!rst_n)
      w_swrst |=> (sec_q == 7'h00) && (min_q == 7'h00) && (hr_q == 6'h00)
         && (date_q == 6'h01) && (mon_q == 5'h01) && (yr_q == 8'h00));
endmodule

bind bcd_clock_bank bcd_clock_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_fail_i(osc_fail_i),
   .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .stop_q(stop_q),
   .osc_q(osc_q), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q),
   .date_q(date_q), .wday_q(wday_q), .mon_q(mon_q), .yr_q(yr_q));

// File: tb/sim_bcd_clock_bank.sv
`timescale 1ns/1ps
module sim_bcd_clock_bank;
   localparam int unsigned AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic          osc_fail_i = 1'b0;
   logic          we_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic [7:0]    wdata_i = '0;
   logic [7:0]    rdata_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic [AW-1:0] a;
      logic [7:0]    exp;
      string         tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #2.5 clk = ~clk;

   bcd_clock_bank #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_fail_i(osc_fail_i),
      .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o));

   // monitor: compares settled read data one step after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rdata_o !== it.exp) begin
               failures++;
               $display("FAIL %s idx=%0h actual=%02h expected=%02h",
                        it.tag, it.a, rdata_o, it.exp);
            end
         end
      end
   end

   // all driver tasks start and end just after a falling edge
   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      sb_item_t it;
      addr_i = a[AW-1:0];
      it.a = a[AW-1:0]; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      we_i = 1'b1; addr_i = a[AW-1:0]; wdata_i = d;
      @(negedge clk);
      we_i = 1'b0;
   endtask

   task automatic wr_tick(input logic [7:0] a, input logic [7:0] d);
      we_i = 1'b1; tick_i = 1'b1; addr_i = a[AW-1:0]; wdata_i = d;
      @(negedge clk);
      we_i = 1'b0; tick_i = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   task automatic set_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic [7:0] w, input logic [7:0] mo,
                          input logic [7:0] y);
      wr(8'h03, s); wr(8'h04, m); wr(8'h05, h); wr(8'h06, d);
      wr(8'h07, w); wr(8'h08, mo); wr(8'h09, y);
   endtask

   // set 23:59:59 on a given date and step once
   task automatic roll_day(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
      set_all(8'h59, 8'h59, 8'h23, d, 8'h02, mo, y);
      tick(1);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h00, 8'h00, "R1 ctrl");
      rd(8'h03, 8'h80, "R1 sec");
      rd(8'h04, 8'h00, "R1 min");
      rd(8'h05, 8'h00, "R1 hour");
      rd(8'h06, 8'h01, "R1 date");
      rd(8'h07, 8'h00, "R1 wday");
      rd(8'h08, 8'h01, "R1 month");
      rd(8'h09, 8'h00, "R1 year");

      // R10 sticky oscillator flag
      wr(8'h03, 8'h00);           rd(8'h03, 8'h00, "R10 cleared");
      osc_fail_i = 1'b1; @(negedge clk); osc_fail_i = 1'b0;
      rd(8'h03, 8'h80, "R10 set by event");
      wr(8'h03, 8'h85);           rd(8'h03, 8'h85, "R10 write 1 keeps");
      osc_fail_i = 1'b1; wr(8'h03, 8'h10); osc_fail_i = 1'b0;
      rd(8'h03, 8'h90, "R10 event beats clear");
      wr(8'h03, 8'h10);           rd(8'h03, 8'h10, "R10 cleared again");

      // R2 seconds
      wr(8'h03, 8'h58); tick(1);  rd(8'h03, 8'h59, "R2 58->59");
      tick(1);
      rd(8'h03, 8'h00, "R2 59->00");
      rd(8'h04, 8'h01, "R2 carry min");
      wr(8'h03, 8'h09); tick(1);  rd(8'h03, 8'h10, "R2 bcd digit");

      // R3 minutes
      set_all(8'h59, 8'h59, 8'h05, 8'h10, 8'h01, 8'h06, 8'h25);
      tick(1);
      rd(8'h04, 8'h00, "R3 min 59->00");
      rd(8'h05, 8'h06, "R3 carry hour");

      // R4 R8 day boundary in 24-hour format
      set_all(8'h59, 8'h59, 8'h23, 8'h14, 8'h06, 8'h03, 8'h25);
      tick(1);
      rd(8'h05, 8'h00, "R4 23->00");
      rd(8'h06, 8'h15, "R4 date carry");
      rd(8'h07, 8'h00, "R8 wday 6->0");
      rd(8'h08, 8'h03, "R4 month unchanged");
      set_all(8'h59, 8'h59, 8'h09, 8'h14, 8'h03, 8'h03, 8'h25);
      tick(1);
      rd(8'h05, 8'h10, "R4 09->10");
      rd(8'h07, 8'h03, "R8 no step mid-day");

      // R6 month lengths and leap years
      roll_day(8'h30, 8'h04, 8'h25);
      rd(8'h06, 8'h01, "R6 Apr30 date"); rd(8'h08, 8'h05, "R6 Apr30 month");
      roll_day(8'h30, 8'h05, 8'h25);
      rd(8'h06, 8'h31, "R6 May30->31");
      roll_day(8'h31, 8'h01, 8'h25);
      rd(8'h06, 8'h01, "R6 Jan31 date"); rd(8'h08, 8'h02, "R6 Jan31 month");
      roll_day(8'h28, 8'h02, 8'h24);
      rd(8'h06, 8'h29, "R6 leap 24 Feb28->29");
      roll_day(8'h29, 8'h02, 8'h24);
      rd(8'h06, 8'h01, "R6 leap Feb29 date"); rd(8'h08, 8'h03, "R6 leap Feb29 month");
      roll_day(8'h28, 8'h02, 8'h23);
      rd(8'h06, 8'h01, "R6 common Feb28 date"); rd(8'h08, 8'h03, "R6 common Feb28 month");
      roll_day(8'h28, 8'h02, 8'h00);
      rd(8'h06, 8'h29, "R6 leap 00");
      roll_day(8'h28, 8'h02, 8'h12);
      rd(8'h06, 8'h29, "R6 leap 12");
      roll_day(8'h28, 8'h02, 8'h10);
      rd(8'h06, 8'h01, "R6 common 10");

      // R7 month and year
      roll_day(8'h31, 8'h12, 8'h99);
      rd(8'h06, 8'h01, "R7 Dec31 date"); rd(8'h08, 8'h01, "R7 month 12->01");
      rd(8'h09, 8'h00, "R7 year 99->00");
      roll_day(8'h31, 8'h12, 8'h19);
      rd(8'h09, 8'h20, "R7 year bcd 19->20");
      roll_day(8'h30, 8'h09, 8'h19);
      rd(8'h08, 8'h10, "R7 month 09->10");

      // R5 12-hour format
      wr(8'h00, 8'h08);           rd(8'h00, 8'h08, "R5 ctrl readback");
      set_all(8'h59, 8'h59, 8'h11, 8'h10, 8'h01, 8'h06, 8'h25);
      tick(1);
      rd(8'h05, 8'h32, "R5 11AM->12PM"); rd(8'h06, 8'h10, "R5 no date carry");
      wr(8'h03, 8'h59); wr(8'h04, 8'h59); tick(1);
      rd(8'h05, 8'h21, "R5 12PM->01PM");
      wr(8'h03, 8'h59); wr(8'h04, 8'h59); wr(8'h05, 8'h31); tick(1);
      rd(8'h05, 8'h12, "R5 11PM->12AM"); rd(8'h06, 8'h11, "R5 date carry");
      rd(8'h07, 8'h02, "R5 wday carry");
      wr(8'h03, 8'h59); wr(8'h04, 8'h59); tick(1);
      rd(8'h05, 8'h01, "R5 12AM->01AM");
      wr(8'h03, 8'h59); wr(8'h04, 8'h59); wr(8'h05, 8'h29); tick(1);
      rd(8'h05, 8'h30, "R5 09PM->10PM");
      wr(8'h00, 8'h00);

      // R9 halt
      wr(8'h00, 8'h20); wr(8'h03, 8'h10);
      rd(8'h00, 8'h20, "R9 ctrl readback");
      tick(3);
      rd(8'h03, 8'h10, "R9 frozen");
      wr(8'h00, 8'h00); tick(1);
      rd(8'h03, 8'h11, "R9 resumed");

      // R11 write against tick
      wr(8'h03, 8'h20);
      wr_tick(8'h03, 8'h30);
      rd(8'h03, 8'h30, "R11 write beats tick");
      set_all(8'h59, 8'h10, 8'h05, 8'h10, 8'h01, 8'h06, 8'h25);
      wr_tick(8'h04, 8'h20);
      rd(8'h04, 8'h20, "R11 min written");
      rd(8'h03, 8'h00, "R11 sec still rolls");
      set_all(8'h59, 8'h10, 8'h05, 8'h10, 8'h01, 8'h06, 8'h25);
      wr_tick(8'h03, 8'h40);
      rd(8'h04, 8'h10, "R11 no carry from written sec");

      // R13 unmapped indices
      wr(8'h0A, 8'h55);
      rd(8'h0A, 8'h00, "R13 unmapped read");
      rd(8'h01, 8'h00, "R13 gap read");
      rd(8'h04, 8'h10, "R13 min untouched");
      rd(8'h09, 8'h25, "R13 year untouched");

      // R12 software reset
      wr(8'h00, 8'h28);
      wr(8'h00, 8'h18);
      rd(8'h00, 8'h00, "R12 ctrl");
      rd(8'h03, 8'h80, "R12 sec");
      rd(8'h05, 8'h00, "R12 hour");
      rd(8'h06, 8'h01, "R12 date");
      rd(8'h09, 8'h00, "R12 year");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule